// File: doc/BRIEF.md
# SPI Serial EEPROM Command Front End

This block is the serial slave side of a small byte-wide EEPROM model. It watches an SPI mode 0 link (clock idle low, data sampled on the rising clock edge, driven on the falling edge) through a synchronizer into the system clock domain. It decodes an opcode byte, then the address bytes, then either collects write data or streams read data. All link inputs are oversampled, so the serial clock must run well below the system clock.

Writes are guarded by a write-enable latch. Dedicated enable and disable commands set and clear the latch, and a committed write clears it again. A write reaches the array only when chip select is released exactly on a byte boundary, after at least one complete data byte. When that happens the block emits a one-cycle commit strobe with the address and the data toward the array model. Reads look up the array combinationally through an address output and return bytes most significant bit first, with the address counting upward and wrapping.

The high address bit of reads and writes is carried in bit 3 of the opcode byte. The remaining address bits come from the address bytes that follow.

Top module: `spi_eeprom_front`

## Requirements
- R1: After reset the write-enable latch is clear, `commit_valid` is low and `miso` is low, so a write frame sent first produces no commit.
- R2: Opcode 0x06, completed as a full byte, sets the write-enable latch.
- R3: Opcode 0x04, completed as a full byte, clears the write-enable latch, so a following write frame produces no commit.
- R4: A write opcode (bits 7..4 zero, bits 2..0 = 010) received while the latch is clear is ignored together with the rest of its frame. Later bytes of that frame are not decoded as commands, so a trailing 0x06 byte does not set the latch.
- R5: With the latch set, a write frame of opcode, address byte and data byte, ended by chip select rising with no partial byte pending, gives one commit. The commit address is {opcode bit 3, address byte} and the commit data is the data byte.
- R6: The latch clears when a write commits, so a second write without a new 0x06 produces no commit.
- R7: A chip select rise in the middle of a byte gives no commit and leaves the latch unchanged.
- R8: A write frame ended after the address byte, before any complete data byte, gives no commit and leaves the latch unchanged.
- R9: Extra complete data bytes in one write frame each replace the pending data. The commit carries the last complete byte at the frame's address.
- R10: A read opcode (bits 7..4 zero, bits 2..0 = 011) followed by the address bytes returns on `miso`, MSB first, bytes from the array at {opcode bit 3, address byte}, then the next addresses upward, wrapping from the top address to 0. `miso` changes only after a falling serial clock edge or a chip select rise.
- R11: `commit_valid` is high for exactly one system clock cycle per committed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| cs_n | input | 1 | Chip select, active low |
| miso | output | 1 | Serial data out |
| commit_valid | output | 1 | One-cycle write commit strobe |
| commit_addr | output | ADDR_W (9) | Address of committed byte |
| commit_data | output | 8 | Committed data byte |
| rd_addr | output | ADDR_W (9) | Array read address |
| rd_data | input | 8 | Array read data for rd_addr |

## Verification
Armed writes sweep addresses spaced across the whole range, including both values of the opcode high bit and the end addresses, with data derived arithmetically from the address. A wrong split between the opcode bit and the address byte therefore shows up as a mismatched commit. Frames that each break one rule are then sent: unarmed, disarmed, truncated mid-byte, truncated after the address, over-long and unarmed with a trailing 0x06. Each is followed by a plain write that tells whether the latch moved. Reads start at several addresses, including just below the 255/256 boundary and the top address. This separates correct incrementing and wrapping from a stuck or mis-ordered shift.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

  localparam logic [7:0] CMD_ARM    = 8'h06;
  localparam logic [7:0] CMD_DISARM = 8'h04;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_IDLE
  } phase_e;

  // write opcode: 0000x010
  function automatic logic op_is_write(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b010);
  endfunction

  // read opcode: 0000x011
  function automatic logic op_is_read(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] == 3'b011);
  endfunction

  // high-order address bit carried by the opcode
  function automatic logic op_hi_bit(input logic [7:0] b);
    return b[3];
  endfunction

endpackage

// File: rtl/spi_eep_sync.sv
module spi_eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic mosi,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s,
  output logic cs_low,
  output logic cs_rise
);

  // bit 2: cs_n, bit 1: sclk, bit 0: mosi
  localparam logic [2:0] IDLE_VEC = 3'b100;

  logic [2:0] pipe [STAGES];
  logic [2:0] last;
  logic [2:0] cur;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= IDLE_VEC;
        else        pipe[g] <= {cs_n, sclk, mosi};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= IDLE_VEC;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign cur = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE_VEC;
    else        last <= cur;
  end

  assign sclk_rise = ~cur[2] &  cur[1] & ~last[1];
  assign sclk_fall = ~cur[2] & ~cur[1] &  last[1];
  assign cs_rise   =  cur[2] & ~last[2];
  assign cs_low    = ~cur[2];
  assign mosi_s    =  cur[0];

endmodule

// File: rtl/spi_eep_cmd.sv
module spi_eep_cmd
  import spi_eep_pkg::*;
#(
  parameter int ADDR_BYTES = 1,
  localparam int ALO_W  = 8 * ADDR_BYTES,
  localparam int ADDR_W = ALO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              cs_rise,
  input  logic              mosi_s,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data,
  output logic              rd_load,
  output logic [ADDR_W-1:0] rd_start,
  output logic              rd_active
);

  localparam int AC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [AC_W-1:0] LAST_AB = AC_W'(ADDR_BYTES - 1);

  phase_e            phase;
  logic [2:0]        bit_cnt;
  logic [7:0]        sh;
  logic              wel;
  logic              is_rd;
  logic              hi_bit;
  logic              have_data;
  logic [AC_W-1:0]   abyte_cnt;
  logic [ALO_W-1:0]  addr_lo;
  logic [7:0]        data_q;

  // named internal events
  logic [7:0]        byte_in;
  logic              byte_done;
  logic              at_boundary;
  logic              commit_ok;
  logic [ALO_W+7:0]  addr_cat;
  logic              last_abyte;

  assign byte_in     = {sh[6:0], mosi_s};
  assign byte_done   = sclk_rise && (bit_cnt == 3'd7);
  assign at_boundary = (bit_cnt == 3'd0);
  assign commit_ok   = cs_rise && (phase == PH_WDATA) && have_data && at_boundary && wel;
  assign addr_cat    = {addr_lo, byte_in};
  assign last_abyte  = (abyte_cnt == LAST_AB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_OPCODE;
      bit_cnt      <= 3'd0;
      sh           <= 8'd0;
      wel          <= 1'b0;
      is_rd        <= 1'b0;
      hi_bit       <= 1'b0;
      have_data    <= 1'b0;
      abyte_cnt    <= '0;
      addr_lo      <= '0;
      data_q       <= 8'd0;
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= 8'd0;
      rd_load      <= 1'b0;
    end else begin
      commit_valid <= 1'b0;
      rd_load      <= 1'b0;
      if (cs_rise) begin
        phase     <= PH_OPCODE;
        bit_cnt   <= 3'd0;
        have_data <= 1'b0;
        abyte_cnt <= '0;
        if (commit_ok) begin
          commit_valid <= 1'b1;
          commit_addr  <= {hi_bit, addr_lo};
          commit_data  <= data_q;
          wel          <= 1'b0;
        end
      end else if (sclk_rise) begin
        sh      <= byte_in;
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          unique case (phase)
            PH_OPCODE: begin
              if (byte_in == CMD_ARM) begin
                wel   <= 1'b1;
                phase <= PH_IDLE;
              end else if (byte_in == CMD_DISARM) begin
                wel   <= 1'b0;
                phase <= PH_IDLE;
              end else if (op_is_write(byte_in) && wel) begin
                hi_bit <= op_hi_bit(byte_in);
                is_rd  <= 1'b0;
                phase  <= PH_ADDR;
              end else if (op_is_read(byte_in)) begin
                hi_bit <= op_hi_bit(byte_in);
                is_rd  <= 1'b1;
                phase  <= PH_ADDR;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_ADDR: begin
              addr_lo <= addr_cat[ALO_W-1:0];
              if (last_abyte) begin
                phase   <= is_rd ? PH_RDATA : PH_WDATA;
                rd_load <= is_rd;
              end else begin
                abyte_cnt <= abyte_cnt + AC_W'(1);
              end
            end
            PH_WDATA: begin
              data_q    <= byte_in;
              have_data <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_start  = {hi_bit, addr_lo};
  assign rd_active = (phase == PH_RDATA);

  // R11
  commit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  // R6
  arm_drop_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !wel);

  // R2
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wel));

  // R7
  mid_byte_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !at_boundary) |=> (!commit_valid && (wel == $past(wel))));

  // R4
  unarmed_write_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPCODE && byte_done && op_is_write(byte_in) && !wel)
      |=> (phase == PH_IDLE));

endmodule

// File: rtl/spi_eep_rdout.sv
module spi_eep_rdout #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall,
  input  logic              cs_rise,
  input  logic              rd_load,
  input  logic [ADDR_W-1:0] rd_start,
  input  logic              rd_active,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

  logic [7:0] out_sh;
  logic [2:0] out_cnt;
  logic       miso_q;
  logic       byte_start;

  assign byte_start = (out_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      out_sh  <= 8'd0;
      out_cnt <= 3'd0;
      miso_q  <= 1'b0;
    end else if (cs_rise) begin
      miso_q  <= 1'b0;
      out_cnt <= 3'd0;
    end else if (rd_load) begin
      rd_addr <= rd_start;
      out_cnt <= 3'd0;
    end else if (sclk_fall && rd_active) begin
      if (byte_start) begin
        miso_q  <= rd_data[7];
        out_sh  <= {rd_data[6:0], 1'b0};
        rd_addr <= rd_addr + ADDR_STEP;
      end else begin
        miso_q <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
      out_cnt <= out_cnt + 3'd1;
    end
  end

  assign miso = miso_q;

  // R10
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_rise) |=> $stable(miso_q));

endmodule

// File: rtl/spi_eeprom_front.sv
module spi_eeprom_front #(
  parameter int ADDR_BYTES  = 1,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 8 * ADDR_BYTES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [7:0]        commit_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              mosi_s;
  logic              cs_low;
  logic              cs_rise;
  logic              rd_load;
  logic [ADDR_W-1:0] rd_start;
  logic              rd_active;

  spi_eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .cs_low    (cs_low),
    .cs_rise   (cs_rise)
  );

  spi_eep_cmd #(.ADDR_BYTES(ADDR_BYTES)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_rise    (sclk_rise),
    .cs_rise      (cs_rise),
    .mosi_s       (mosi_s),
    .commit_valid (commit_valid),
    .commit_addr  (commit_addr),
    .commit_data  (commit_data),
    .rd_load      (rd_load),
    .rd_start     (rd_start),
    .rd_active    (rd_active)
  );

  spi_eep_rdout #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_fall (sclk_fall),
    .cs_rise   (cs_rise),
    .rd_load   (rd_load),
    .rd_start  (rd_start),
    .rd_active (rd_active),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .miso      (miso)
  );

  // R1
  no_commit_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && !cs_rise) |=> !commit_valid);

endmodule

// File: tb/spi_eeprom_front_tb.sv
module spi_eeprom_front_tb;

  localparam int CLK_NS = 10;
  localparam int HALF   = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       cs_n = 1'b1;
  logic       miso;
  logic       commit_valid;
  logic [8:0] commit_addr;
  logic [7:0] commit_data;
  logic [8:0] rd_addr;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  int ncommit = 0;
  int wide = 0;
  logic [8:0] last_addr = '0;
  logic [7:0] last_data = '0;
  logic prev_cv = 1'b0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  spi_eeprom_front u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .mosi         (mosi),
    .cs_n         (cs_n),
    .miso         (miso),
    .commit_valid (commit_valid),
    .commit_addr  (commit_addr),
    .commit_data  (commit_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [8:0] a);
    logic [15:0] p;
    p = {7'd0, a} * 16'd37 + 16'd11;
    return p[7:0] ^ {1'b0, a[8:2]};
  endfunction

  assign rd_data = mem_f(rd_addr);

  always @(posedge clk) begin
    prev_cv <= commit_valid;
    if (commit_valid) begin
      ncommit   <= ncommit + 1;
      last_addr <= commit_addr;
      last_data <= commit_data;
      if (prev_cv) wide <= wide + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'd0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic one_byte_frame(input logic [7:0] b);
    logic [7:0] rx;
    sel(); xfer(b, rx); desel();
  endtask

  function automatic logic [7:0] wr_op(input logic [8:0] a);
    return 8'h02 | {4'd0, a[8], 3'd0};
  endfunction

  task automatic write_frame(input logic [8:0] a, input logic [7:0] d);
    logic [7:0] rx;
    sel(); xfer(wr_op(a), rx); xfer(a[7:0], rx); xfer(d, rx); desel();
  endtask

  task automatic expect_commit(input string req, input int n0, input logic [8:0] a, input logic [7:0] d);
    chk(ncommit == n0 + 1, req, ncommit - n0, 1);
    chk(last_addr == a, req, last_addr, a);
    chk(last_data == d, req, last_data, d);
  endtask

  task automatic expect_none(input string req, input int n0);
    chk(ncommit == n0, req, ncommit - n0, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [7:0] rx;
    logic [8:0] a;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state
    chk(miso == 1'b0, "R1 miso", miso, 0);
    chk(commit_valid == 1'b0, "R1 commit_valid", commit_valid, 0);
    n0 = ncommit;
    write_frame(9'h055, 8'hAA);
    expect_none("R1 unarmed after reset", n0);

    // R2 R5: armed write sweep, R6 auto clear
    for (int k = 0; k < 44; k++) begin
      a = (k < 40) ? 9'(k * 13) : ((k == 40) ? 9'h0FF : (k == 41) ? 9'h100 : (k == 42) ? 9'h1FF : 9'h000);
      n0 = ncommit;
      one_byte_frame(8'h06);
      write_frame(a, mem_f(a));
      expect_commit("R5 armed write", n0, a, mem_f(a));
    end
    n0 = ncommit;
    write_frame(9'h123, 8'h5A);
    expect_none("R6 re-arm needed", n0);

    // R3: disarm
    n0 = ncommit;
    one_byte_frame(8'h06);
    one_byte_frame(8'h04);
    write_frame(9'h010, 8'h11);
    expect_none("R3 disarm", n0);

    // R4: unarmed write with trailing 0x06
    n0 = ncommit;
    sel(); xfer(8'h02, rx); xfer(8'h06, rx); xfer(8'h06, rx); desel();
    write_frame(9'h020, 8'h22);
    expect_none("R4 unarmed write ignored", n0);

    // R7: mid-byte release keeps latch
    n0 = ncommit;
    one_byte_frame(8'h06);
    sel(); xfer(wr_op(9'h1A5), rx); xfer(8'hA5, rx); xfer_bits(8'h3C, 5, rx); desel();
    expect_none("R7 mid-byte drop", n0);
    write_frame(9'h1A5, 8'hC3);
    expect_commit("R7 latch kept", n0, 9'h1A5, 8'hC3);

    // R8: release after address only
    n0 = ncommit;
    one_byte_frame(8'h06);
    sel(); xfer(wr_op(9'h077), rx); xfer(8'h77, rx); desel();
    expect_none("R8 no data byte", n0);
    write_frame(9'h077, 8'h99);
    expect_commit("R8 latch kept", n0, 9'h077, 8'h99);

    // R9: extra data bytes, last one wins
    n0 = ncommit;
    one_byte_frame(8'h06);
    sel(); xfer(wr_op(9'h1C0), rx); xfer(8'hC0, rx);
    xfer(8'h12, rx); xfer(8'h34, rx); xfer(8'h56, rx); desel();
    expect_commit("R9 last byte", n0, 9'h1C0, 8'h56);

    // R11: strobe width
    chk(wide == 0, "R11 pulse width", wide, 0);

    // R10: reads with increment and wrap
    for (int s = 0; s < 5; s++) begin
      logic [8:0] st;
      st = (s == 0) ? 9'h000 : (s == 1) ? 9'h0FE : (s == 2) ? 9'h1FE : (s == 3) ? 9'h12C : 9'h1FF;
      sel();
      xfer(8'h03 | {4'd0, st[8], 3'd0}, rx);
      xfer(st[7:0], rx);
      for (int k = 0; k < 4; k++) begin
        logic [8:0] ea;
        ea = st + 9'(k);
        xfer(8'h00, rx);
        chk(rx == mem_f(ea), "R10 read byte", rx, mem_f(ea));
      end
      desel();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule